// File: doc/BRIEF.md
# Fourth-Order Noise-Shaping Fraction Modulator

This block turns a fractional setting into a stream of small signed corrections. A coarse PWM compare value can only move in whole counts. Adding one of these corrections to it on every PWM period gives the average duty cycle a resolution finer than one count. Four overflowing accumulators are chained. The first accumulates the fraction. Each later one accumulates the new residue of the stage before it. Every accumulator wraps at a programmable modulus, which can be any integer and need not be a power of two. A modulus of about 17 500, for instance, makes one fraction count equal one target unit.

The carries of the four stages are combined into one value. Stage k goes through a (k-1)-th order first-difference network, and the results are added. The output is a 5-bit two's-complement number between -7 and +8. Values near the middle come out more often than the extremes. Over a long run the mean of the output equals fraction / modulus, and the quantisation error is pushed towards high frequencies, where the PWM filter removes it.

Each pulse on the step strobe makes one step, normally once per PWM period. The result is registered and flagged valid on the clock after the step. The step strobe is the input valid. The output has no ready and cannot be stalled: a consumer must accept each value in the cycle its valid flag is high.

Top module: `mash4_mod`

## Requirements
- R1: While reset is asserted, and after its release until the first step, `mod_o` is 0 and `mod_valid_o` is 0.
- R2: `mod_valid_o` is high for exactly the one clock that follows a clock in which `step_i` was high, and is low otherwise.
- R3: Accumulators, difference registers and `mod_o` change only on a clock in which `step_i` is high. Clocks without a step leave the internal state untouched, even if `frac_i` changes meanwhile.
- R4: Each stage update works as follows.
  - With residues r1..r4, all 0 after reset, stage 1 forms s = r1 + frac_i. If s >= modulus, it sets carry c1 = 1 and r1 = s - modulus. Otherwise c1 = 0 and r1 = s.
  - Stage k (k = 2..4) does the same with addend = the new residue of stage k-1.
  - The output of that step is y = c1 + (c2 - c2') + (c3 - 2c3' + c3'') + (c4 - 3c4' + 3c4'' - c4''').
  - Primes mark the carries of the previous one, two and three steps, which are 0 before the first step.
- R5: `mod_o` is 5-bit two's complement and always lies in -7..+8.
- R6: For any run of N steps from reset with a constant fraction x and modulus M, the output sum S satisfies |M*S - N*x| <= 5*M. Over a long run the mean is therefore x/M.
- R7: The modulus may be any integer from 1 up to 2^ACC_W - 1, including values that are not powers of two (e.g. 3, 10, 17500). `frac_i` must be below the modulus.
- R8: With `frac_i` = 0 from reset on, every output is 0.
- R9: For a fraction well inside (0, M), the outputs 0 and +1 each occur more often than -7 and +8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step strobe: one modulator step per high cycle |
| frac_i | input | ACC_W | Fractional input, must be below `modulus_i` |
| modulus_i | input | ACC_W | Accumulator wrap modulus, at least 1 |
| mod_o | output | 5 | Signed modulation value, two's complement |
| mod_valid_o | output | 1 | High for one clock when `mod_o` holds a new value |

## Verification
Every step result appears exactly one clock after the clock edge that samples `step_i`. The bench raises `step_i` on a falling edge and drops it on the next falling edge. It then reads `mod_o` and `mod_valid_o` at that falling edge, half a clock after the edge that registered them, and compares the value with its own step-by-step evaluation of the R4 equations. For the hold and valid-pulse checks it also samples at the falling edges of the idle clocks that follow, where `mod_valid_o` must be low and `mod_o` unchanged.

// File: rtl/mash4_pkg.sv
package mash4_pkg;
  localparam int ORDER = 4;
  localparam int OUT_W = 5;
  typedef logic signed [OUT_W-1:0] mod_t;

  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 1; i <= k; i++) begin
      r = (r * (n - i + 1)) / i;
    end
    return r;
  endfunction
endpackage

// File: rtl/mash4_acc_stage.sv
module mash4_acc_stage #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] addend_i,
  input  logic [W-1:0] modulus_i,
  output logic [W-1:0] resid_next_o,
  output logic         carry_o
);
  logic [W-1:0] resid_q;
  logic [W:0]   sum;

  always_comb begin
    sum     = {1'b0, resid_q} + {1'b0, addend_i};
    carry_o = (sum >= {1'b0, modulus_i});
    if (carry_o) resid_next_o = W'(sum - {1'b0, modulus_i});
    else         resid_next_o = sum[W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    resid_q <= '0;
    else if (adv_i) resid_q <= resid_next_o;
  end
endmodule

// File: rtl/mash4_diff.sv
module mash4_diff
  import mash4_pkg::*;
#(
  parameter int DEPTH = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic carry_i,
  output mod_t term_o
);
  localparam int NREG = (DEPTH > 0) ? DEPTH : 1;

  logic [NREG-1:0] hist_q;

  generate
    if (DEPTH > 0) begin : g_hist
      always_ff @(posedge clk_i) begin
        if (!rst_ni)    hist_q <= '0;
        else if (adv_i) hist_q <= {hist_q[NREG-2+((NREG>1)?0:1):0], carry_i};
      end
    end else begin : g_nohist
      assign hist_q = '0;
    end
  endgenerate

  int acc;
  always_comb begin
    acc = carry_i ? 1 : 0;
    for (int k = 1; k <= DEPTH; k++) begin
      if (hist_q[k-1]) begin
        if ((k % 2) == 1) acc = acc - binom(DEPTH, k);
        else              acc = acc + binom(DEPTH, k);
      end
    end
    term_o = acc[OUT_W-1:0];
  end
endmodule

// File: rtl/mash4_mod.sv
module mash4_mod
  import mash4_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [ACC_W-1:0] frac_i,
  input  logic [ACC_W-1:0] modulus_i,
  output logic [OUT_W-1:0] mod_o,
  output logic             mod_valid_o
);
  logic [ACC_W-1:0] resid_next [ORDER];
  logic [ORDER-1:0] carry;
  mod_t             term [ORDER];
  mod_t             sum_d;

  generate
    for (genvar s = 0; s < ORDER; s++) begin : g_stage
      logic [ACC_W-1:0] addend;
      if (s == 0) begin : g_first
        assign addend = frac_i;
      end else begin : g_chain
        assign addend = resid_next[s-1];
      end

      mash4_acc_stage #(.W(ACC_W)) acc_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .adv_i        (step_i),
        .addend_i     (addend),
        .modulus_i    (modulus_i),
        .resid_next_o (resid_next[s]),
        .carry_o      (carry[s])
      );

      mash4_diff #(.DEPTH(s)) diff_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (step_i),
        .carry_i (carry[s]),
        .term_o  (term[s])
      );
    end
  endgenerate

  always_comb begin
    sum_d = '0;
    for (int s = 0; s < ORDER; s++) sum_d = sum_d + term[s];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mod_o       <= '0;
      mod_valid_o <= 1'b0;
    end else begin
      mod_valid_o <= step_i;
      if (step_i) mod_o <= sum_d;
    end
  end
endmodule

// File: rtl/mash4_mod_chk.sv
module mash4_mod_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic [ACC_W-1:0] frac_i,
  input logic [4:0]       mod_o,
  input logic             mod_valid_o
);
  AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> mod_valid_o); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !mod_valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(mod_o)); // R3
  AST_OUT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o |-> ($signed(mod_o) >= -5'sd7)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (!mod_valid_o && mod_o == 5'd0)); // R1
endmodule

bind mash4_mod mash4_mod_chk #(.ACC_W(ACC_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .frac_i      (frac_i),
  .mod_o       (mod_o),
  .mod_valid_o (mod_valid_o)
);

// File: tb/mash4_mod_tb.sv
module mash4_mod_tb_top;
  localparam int ACC_W = 24;
  localparam int NCASE = 8;
  localparam int NSTEP = 600;
  localparam logic [ACC_W-1:0] FRAC_T [NCASE] = '{24'd1, 24'd2, 24'd3, 24'd5000,
                                                 24'd17499, 24'd0, 24'd1234567, 24'd1};
  localparam logic [ACC_W-1:0] MOD_T  [NCASE] = '{24'd8, 24'd8, 24'd10, 24'd17500,
                                                 24'd17500, 24'd1, 24'd9999991, 24'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [ACC_W-1:0] frac = '0;
  logic [ACC_W-1:0] modv = 24'd8;
  logic [4:0] mod_o;
  logic mod_valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mash4_mod #(.ACC_W(ACC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .frac_i(frac),
    .modulus_i(modv), .mod_o(mod_o), .mod_valid_o(mod_valid_o)
  );

  longint r [4];
  int c2d, c3d, c3dd, c4d, c4dd, c4ddd;

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) r[i] = 0;
    c2d = 0; c3d = 0; c3dd = 0; c4d = 0; c4dd = 0; c4ddd = 0;
  endfunction

  function automatic int model_step(input longint x, input longint m);
    int c [4];
    longint add, s;
    int y;
    add = x;
    for (int i = 0; i < 4; i++) begin
      s = r[i] + add;
      if (s >= m) begin c[i] = 1; s = s - m; end else c[i] = 0;
      r[i] = s;
      add = s;
    end
    y = c[0] + (c[1] - c2d) + (c[2] - 2*c3d + c3dd) + (c[3] - 3*c4d + 3*c4dd - c4ddd);
    c2d = c[1];
    c3dd = c3d; c3d = c[2];
    c4ddd = c4dd; c4dd = c4d; c4d = c[3];
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; step = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_step(output int y);
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
    y = $signed(mod_o);
  endtask

  int y, e, sum, hist [17];
  longint lhs;

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mod_o == 5'd0, "R1 mod_o in reset", mod_o, 0);
    check(!mod_valid_o, "R1 valid in reset", mod_valid_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mod_o == 5'd0 && !mod_valid_o, "R1 after release", mod_o, 0);

    // table walk: R4 exact sequence, R5 range, R6 mean, R7 modulus values, R8 zero input
    for (int t = 0; t < NCASE; t++) begin
      frac = FRAC_T[t]; modv = MOD_T[t];
      do_reset();
      sum = 0;
      for (int n = 0; n < NSTEP; n++) begin
        do_step(y);
        e = model_step(FRAC_T[t], MOD_T[t]);
        sum += y;
        check(y == e, "R4/R7 step value", y, e);
        check(y >= -7 && y <= 8, "R5 range", y, 0);
        check(mod_valid_o == 1'b1, "R2 valid after step", mod_valid_o, 1);
        if (FRAC_T[t] == 0) check(y == 0, "R8 zero input", y, 0);
      end
      lhs = longint'(MOD_T[t]) * sum - longint'(NSTEP) * FRAC_T[t];
      if (lhs < 0) lhs = -lhs;
      check(lhs <= 5 * longint'(MOD_T[t]), "R6 mean", sum, NSTEP * FRAC_T[t] / MOD_T[t]);
    end

    // R2/R3: gaps between steps, input changes while idle
    frac = 24'd5000; modv = 24'd17500;
    do_reset();
    for (int n = 0; n < 40; n++) begin
      do_step(y);
      e = model_step(5000, 17500);
      check(y == e, "R3 step value with gaps", y, e);
      frac = 24'd17000;
      @(negedge clk);
      check(!mod_valid_o, "R2 valid low when idle", mod_valid_o, 0);
      check($signed(mod_o) == e, "R3 hold when idle", $signed(mod_o), e);
      @(negedge clk);
      check($signed(mod_o) == e, "R3 hold second idle clock", $signed(mod_o), e);
      frac = 24'd5000;
    end

    // R9: histogram mid vs extremes
    frac = 24'd5000; modv = 24'd17500;
    do_reset();
    for (int i = 0; i < 17; i++) hist[i] = 0;
    for (int n = 0; n < 3000; n++) begin
      do_step(y);
      if (y >= -8 && y <= 8) hist[y + 8]++;
    end
    check(hist[8] > hist[1] && hist[8] > hist[16], "R9 zero vs extremes", hist[8], hist[1] + hist[16]);
    check(hist[9] > hist[1] && hist[9] > hist[16], "R9 one vs extremes", hist[9], hist[1] + hist[16]);

    // R1: reset mid-run clears
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(mod_o == 5'd0 && !mod_valid_o, "R1 reset mid-run", mod_o, 0);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule